// File: doc/BRIEF.md
# Nonvolatile Write Permission Gate

This block sits in front of a byte-wide nonvolatile store and decides, one request at a time, whether a write may go ahead. It keeps a one-byte protection register. The register is reached at the topmost address of the 16-bit space, and it holds three controls:

- a software write latch that must be set before anything is written;
- a two-bit field that locks a share of the address space against array writes;
- an enable bit that, together with an external protect pin, freezes the register itself.

A requester presents a write as an address and data byte with a valid strobe, together with the current level of the protect pin. One clock later the block answers with a one-cycle grant or a one-cycle deny. A granted write aimed at the register address updates the register in that same clock. A granted write elsewhere is left to the array logic, which is not part of this block. A denied write changes nothing.

The register contents are always visible on an output bus, so the array side and any observer can see the active protection settings. The register is held in an ordinary flop and clears on reset.

Top module: `wprot_ctrl`

## Requirements
- R1: The register reads out on `prot_reg_o` with the write latch in bit 1, the lock select in bits 4:3 and the hardware freeze enable in bit 7. All other bits read 0, and the whole byte is 0x00 after reset.
- R2: While the write latch is clear, every write to an address other than FFFFh is denied.
- R3: While the write latch is clear, a write to FFFFh with data exactly 0x02 is granted and sets only the latch. Any other data value to FFFFh is denied.
- R4: While the latch is set and the register is not frozen, a write to FFFFh is granted and loads bits 1, 4:3 and 7 from the data byte. Writing 0 to bit 1 clears the latch.
- R5: With the latch set, the lock select decides which array writes are denied. 00 denies none, 01 denies C000h and above, 10 denies 8000h and above, and 11 denies every address. The decision uses the two top address bits. Writes outside the locked range are granted.
- R6: While the protect pin is low, or the freeze enable bit is clear, register writes follow only R3 and R4.
- R7: While the protect pin is high and the freeze enable bit is set, every write to FFFFh is denied, including a latch set. Array writes still follow R2 and R5.
- R8: Every request cycle is followed in the next cycle by exactly one of `wr_grant_o` or `wr_deny_o`, each high for one cycle. Without a request, both stay low.
- R9: A denied write leaves `prot_reg_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid_i | input | 1 | Write request strobe, one per cycle |
| wr_addr_i | input | 16 | Target byte address |
| wr_data_i | input | 8 | Data byte of the write |
| prot_pin_i | input | 1 | External protect pin level |
| wr_grant_o | output | 1 | Previous-cycle request allowed |
| wr_deny_o | output | 1 | Previous-cycle request refused |
| prot_reg_o | output | 8 | Current protection register byte |

## Verification
The bench probes each lock range at both edges: BFFFh against C000h, 7FFFh against 8000h, and FFFEh, which is the last array byte below the register. A design that compared the wrong address bits would grant or deny on the wrong side of a boundary.

It sends a latch-set value with extra bits set while the latch is clear. A design that took any value with bit 1 set would grant that write and load the extra bits early.

It raises the protect pin both with the freeze enable set and with it clear. A design that gated on the pin alone would refuse the second case. A design that let the latch-set write through a frozen register would show a changed byte.

Requests also arrive back to back, so a decision pulse that lasted longer than one cycle would merge into the next.

// File: rtl/wp_pkg.sv
package wp_pkg;
  localparam int BYTE_W  = 8;
  localparam int WEL_BIT = 1;
  localparam int LSEL_LO = 3;
  localparam int HPE_BIT = 7;

  typedef enum logic [1:0] {
    LK_NONE = 2'b00,
    LK_QTR  = 2'b01,
    LK_HALF = 2'b10,
    LK_ALL  = 2'b11
  } lock_sel_e;

  typedef struct packed {
    logic      hpe;
    logic      wel;
    lock_sel_e lsel;
  } prot_fields_t;

  localparam prot_fields_t FIELDS_RST = '{hpe: 1'b0, wel: 1'b0, lsel: LK_NONE};

  function automatic logic [BYTE_W-1:0] pack_fields(prot_fields_t f);
    logic [BYTE_W-1:0] b;
    b = '0;
    b[WEL_BIT] = f.wel;
    b[LSEL_LO +: 2] = f.lsel;
    b[HPE_BIT] = f.hpe;
    return b;
  endfunction

  function automatic prot_fields_t unpack_fields(logic [BYTE_W-1:0] b);
    prot_fields_t f;
    f.wel  = b[WEL_BIT];
    f.lsel = lock_sel_e'(b[LSEL_LO +: 2]);
    f.hpe  = b[HPE_BIT];
    return f;
  endfunction

  function automatic logic [BYTE_W-1:0] latch_only_value();
    logic [BYTE_W-1:0] b;
    b = '0;
    b[WEL_BIT] = 1'b1;
    return b;
  endfunction

  function automatic logic top_bits_locked(lock_sel_e s, logic [1:0] top2);
    logic r;
    unique case (s)
      LK_NONE: r = 1'b0;
      LK_QTR:  r = (top2 == 2'b11);
      LK_HALF: r = top2[1];
      default: r = 1'b1;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/wp_addr_decode.sv
module wp_addr_decode
  import wp_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  lock_sel_e         lsel_i,
  output logic              is_reg_o,
  output logic              in_lock_o
);
  localparam logic [ADDR_W-1:0] REG_ADDR = {ADDR_W{1'b1}};
  localparam int TOP_LO = ADDR_W - 2;

  logic [1:0] top2;

  assign top2      = addr_i[ADDR_W-1:TOP_LO];
  assign is_reg_o  = (addr_i == REG_ADDR);
  assign in_lock_o = top_bits_locked(lsel_i, top2);
endmodule

// File: rtl/wp_policy.sv
module wp_policy
  import wp_pkg::*;
(
  input  logic              valid_i,
  input  logic              is_reg_i,
  input  logic              in_lock_i,
  input  logic [BYTE_W-1:0] data_i,
  input  prot_fields_t      cur_i,
  input  logic              pin_i,
  output logic              allow_o,
  output logic              refuse_o,
  output logic              load_o,
  output prot_fields_t      next_o,
  output logic              frozen_o
);
  logic latch_only;

  assign frozen_o   = pin_i & cur_i.hpe;
  assign latch_only = (data_i == latch_only_value());

  always_comb begin
    allow_o  = 1'b0;
    refuse_o = 1'b0;
    load_o   = 1'b0;
    next_o   = cur_i;
    if (valid_i) begin
      if (is_reg_i) begin
        if (frozen_o) begin
          refuse_o = 1'b1;
        end else if (!cur_i.wel) begin
          if (latch_only) begin
            allow_o    = 1'b1;
            load_o     = 1'b1;
            next_o.wel = 1'b1;
          end else begin
            refuse_o = 1'b1;
          end
        end else begin
          allow_o = 1'b1;
          load_o  = 1'b1;
          next_o  = unpack_fields(data_i);
        end
      end else begin
        if (!cur_i.wel || in_lock_i) refuse_o = 1'b1;
        else                         allow_o  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/wp_reg.sv
module wp_reg
  import wp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  prot_fields_t      next_i,
  output prot_fields_t      cur_o,
  output logic [BYTE_W-1:0] byte_o
);
  prot_fields_t q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= FIELDS_RST;
    else if (load_i) q <= next_i;
  end

  assign cur_o  = q;
  assign byte_o = pack_fields(q);
endmodule

// File: rtl/wprot_ctrl.sv
module wprot_ctrl
  import wp_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic              prot_pin_i,
  output logic              wr_grant_o,
  output logic              wr_deny_o,
  output logic [7:0]        prot_reg_o
);
  logic         is_reg_w;
  logic         in_lock_w;
  logic         allow_w;
  logic         refuse_w;
  logic         load_w;
  logic         frozen_w;
  prot_fields_t cur_w;
  prot_fields_t next_w;
  logic         grant_q;
  logic         deny_q;

  wp_addr_decode #(.ADDR_W(ADDR_W)) i_dec (
    .addr_i    (wr_addr_i),
    .lsel_i    (cur_w.lsel),
    .is_reg_o  (is_reg_w),
    .in_lock_o (in_lock_w)
  );

  wp_policy i_pol (
    .valid_i   (wr_valid_i),
    .is_reg_i  (is_reg_w),
    .in_lock_i (in_lock_w),
    .data_i    (wr_data_i),
    .cur_i     (cur_w),
    .pin_i     (prot_pin_i),
    .allow_o   (allow_w),
    .refuse_o  (refuse_w),
    .load_o    (load_w),
    .next_o    (next_w),
    .frozen_o  (frozen_w)
  );

  wp_reg i_reg (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (load_w),
    .next_i (next_w),
    .cur_o  (cur_w),
    .byte_o (prot_reg_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q <= 1'b0;
      deny_q  <= 1'b0;
    end else begin
      grant_q <= allow_w;
      deny_q  <= refuse_w;
    end
  end

  assign wr_grant_o = grant_q;
  assign wr_deny_o  = deny_q;
endmodule

// File: rtl/wprot_ctrl_chk.sv
module wprot_ctrl_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic              prot_pin_i,
  input logic              wr_grant_o,
  input logic              wr_deny_o,
  input logic [7:0]        prot_reg_o,
  input logic              frozen_w,
  input logic              load_w
);
  logic tgt_reg;
  assign tgt_reg = &wr_addr_i;

  AST_SINGLE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_i |=> (wr_grant_o ^ wr_deny_o)); // R8

  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid_i |=> (!wr_grant_o && !wr_deny_o)); // R8

  AST_DENY_KEEPS_REG: assert property (@(posedge clk) disable iff (!rst_n)
    wr_deny_o |-> $stable(prot_reg_o)); // R9

  AST_NO_LATCH_ARRAY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_i && !tgt_reg && !prot_reg_o[1]) |=> wr_deny_o); // R2

  AST_FROZEN_REG: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_i && tgt_reg && prot_pin_i && prot_reg_o[7]) |=> wr_deny_o); // R7

  AST_FROZEN_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    frozen_w |-> !(load_w && tgt_reg)); // R7

  AST_FULL_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_i && !tgt_reg && prot_reg_o[4:3] == 2'b11) |=> wr_deny_o); // R5

  AST_SPARE_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_reg_o[6:5] == 2'b00) && !prot_reg_o[2] && !prot_reg_o[0]); // R1
endmodule

bind wprot_ctrl wprot_ctrl_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_valid_i (wr_valid_i),
  .wr_addr_i  (wr_addr_i),
  .prot_pin_i (prot_pin_i),
  .wr_grant_o (wr_grant_o),
  .wr_deny_o  (wr_deny_o),
  .prot_reg_o (prot_reg_o),
  .frozen_w   (frozen_w),
  .load_w     (load_w)
);

// File: tb/test_wprot_ctrl.sv
`timescale 1ns/1ps
module test_wprot_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid_i = 1'b0;
  logic [15:0] wr_addr_i = '0;
  logic [7:0]  wr_data_i = '0;
  logic        prot_pin_i = 1'b0;
  logic        wr_grant_o;
  logic        wr_deny_o;
  logic [7:0]  prot_reg_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    logic       grant;
    logic [7:0] regv;
    string      tag;
  } exp_t;
  exp_t exp_q[$];

  // reference state
  logic       m_latch = 0;
  logic [1:0] m_sel   = 0;
  logic       m_frz   = 0;

  always #10 clk = ~clk;

  wprot_ctrl i_wprot_ctrl (.*);

  function automatic logic [7:0] m_byte();
    return {m_frz, 2'b00, m_sel, 1'b0, m_latch, 1'b0};
  endfunction

  function automatic logic locked(logic [1:0] sel, logic [15:0] a);
    case (sel)
      2'd1: return a >= 16'hC000;
      2'd2: return a >= 16'h8000;
      2'd3: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic put(input logic [15:0] a, input logic [7:0] d, input logic pin, input string tag);
    exp_t e;
    logic ok;
    @(negedge clk);
    wr_valid_i = 1'b1; wr_addr_i = a; wr_data_i = d; prot_pin_i = pin;
    if (a == 16'hFFFF) begin
      if (pin && m_frz) ok = 0;
      else if (!m_latch) begin
        ok = (d == 8'h02);
        if (ok) m_latch = 1;
      end else begin
        ok = 1;
        m_latch = d[1]; m_sel = d[4:3]; m_frz = d[7];
      end
    end else begin
      ok = m_latch && !locked(m_sel, a);
    end
    e.grant = ok; e.regv = m_byte(); e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_valid_i = 1'b0;
    end
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      logic had;
      @(posedge clk);
      had = wr_valid_i && rst_n;
      #2;
      if (had) begin
        exp_t e;
        e = exp_q.pop_front();
        checks++;
        if (wr_grant_o !== e.grant || wr_deny_o !== !e.grant || prot_reg_o !== e.regv) begin
          fails++;
          $display("FAIL %s: grant=%b deny=%b reg=%h expected grant=%b deny=%b reg=%h",
                   e.tag, wr_grant_o, wr_deny_o, prot_reg_o, e.grant, !e.grant, e.regv);
        end
      end else if (rst_n) begin
        checks++;
        if (wr_grant_o !== 1'b0 || wr_deny_o !== 1'b0) begin
          fails++;
          $display("FAIL R8 idle: grant=%b deny=%b expected 0 0", wr_grant_o, wr_deny_o);
        end
      end
    end
  end

  initial begin
    #(20 * 5000);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    done = 1;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (prot_reg_o !== 8'h00 || wr_grant_o !== 0 || wr_deny_o !== 0) begin
      fails++;
      $display("FAIL R1 reset: reg=%h g=%b d=%b expected 00 0 0", prot_reg_o, wr_grant_o, wr_deny_o);
    end
    rst_n = 1'b1;
    idle(2);
    put(16'h0000, 8'h55, 0, "R2 array without latch");
    put(16'h7FFF, 8'h11, 1, "R2 array without latch, pin high");
    put(16'hFFFF, 8'h9A, 0, "R3 wrong latch value");
    put(16'hFFFF, 8'h03, 0, "R3 latch bit plus extra");
    put(16'hFFFF, 8'h02, 0, "R3 latch set");
    put(16'h1234, 8'hAA, 0, "R5 none locked");
    put(16'hFFFE, 8'hAA, 0, "R5 none locked top byte");
    idle(1);
    put(16'hFFFF, 8'h0A, 0, "R4 load quarter lock");
    put(16'hBFFF, 8'h01, 0, "R5 quarter below edge");
    put(16'hC000, 8'h01, 0, "R5 quarter at edge");
    put(16'hFFFE, 8'h01, 0, "R5 quarter top");
    put(16'hFFFF, 8'h12, 0, "R4 load half lock");
    put(16'h7FFF, 8'h01, 0, "R5 half below edge");
    put(16'h8000, 8'h01, 0, "R5 half at edge");
    put(16'hFFFF, 8'h1A, 0, "R4 load full lock");
    put(16'h0000, 8'h01, 0, "R5 full lock bottom");
    idle(2);
    put(16'hFFFF, 8'hFF, 0, "R1 spare bits read zero");
    put(16'hFFFF, 8'h8A, 0, "R6 pin low ignores freeze");
    put(16'hFFFF, 8'h02, 1, "R7 frozen latch write");
    put(16'hFFFF, 8'h00, 1, "R7 frozen clear write");
    put(16'h1000, 8'h01, 1, "R7 array unlocked while frozen");
    put(16'hC001, 8'h01, 1, "R7 array locked while frozen");
    put(16'hFFFF, 8'h00, 0, "R4 clear all incl latch");
    put(16'h2000, 8'h01, 0, "R2 latch cleared again");
    put(16'hFFFF, 8'h02, 1, "R6 pin high, freeze bit clear");
    put(16'hFFFF, 8'h82, 1, "R6 set freeze while pin high");
    put(16'hFFFF, 8'h02, 1, "R9 frozen write keeps reg");
    idle(3);
    done = 1;
  end

  initial begin
    wait (done);
    #5;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule